// File: doc/BRIEF.md
# Sideband Mailbox Register Bridge

This block is a small register target that lets a host reach endpoints on a sideband bus through three plain 32-bit registers behind a configuration-style register port. The host fills in a data word and an upper-address word, then writes a command word. That command write is the trigger: the bridge pulls the opcode, destination port, low address byte and byte enables out of the command word. It merges the address byte into the upper-address word and issues exactly one request on the sideband bus.

While the request is open, the bridge reports busy. It then waits for the response. A read result lands in the data register, where the host picks it up with an ordinary register read. Commands aimed at one reserved port number belong to another agent. The bridge refuses them without touching the bus and raises a sticky error flag. The host clears that flag by writing a one to it.

Top module: `sbm_bridge`

## Requirements
- R1: After reset, every register reads 0 and no sideband request is valid.
- R2: A command write accepted while idle, with a nonzero byte-enable field in bits [7:4] and a port other than the reserved one, raises a request in the next cycle. The request carries opcode = bits [31:24], port = bits [23:16] and byte enables = bits [7:4].
- R3: The request address is the upper-address register ORed with command bits [15:8] placed at address bits [7:0].
- R4: When opcode bit 0 is 1, the request is a write. It carries the data register as write data, and the data register is left unchanged by the completion.
- R5: When opcode bit 0 is 0, the request is a read. An error-free response stores its read data into the data register.
- R6: A command with byte-enable field 0 issues no request, sets no error and leaves the bridge idle.
- R7: A command aimed at port BLOCKED_PORT (default 8'h06) with nonzero byte enables issues no request and sets the error flag.
- R8: Status bit 0 (busy) reads 1 from the cycle after a launching command write until the response is accepted, and reads 0 otherwise.
- R9: While busy, writes to the command, data and upper-address registers are ignored, and data reads return the value held before the command.
- R10: A raised request keeps all its fields unchanged until the cycle in which ready is seen high.
- R11: A response with its error flag set sets status bit 1 and leaves the data register unchanged.
- R12: Status bit 1 is sticky. Writing status with bit 1 = 1 clears it, and writing it with bit 1 = 0 leaves it as it is.
- R13: Register word offsets are: 0 command (reads back the last command accepted while idle), 1 data, 2 upper address, 3 status. Register reads return their data one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | CFG_AW | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data, valid the cycle after cfg_rd |
| sb_req_valid | output | 1 | Sideband request valid |
| sb_req_ready | input | 1 | Sideband request accepted |
| sb_req_op | output | 8 | Request opcode |
| sb_req_port | output | 8 | Request destination port |
| sb_req_addr | output | SB_AW | Request address |
| sb_req_be | output | 4 | Request byte enables |
| sb_req_wdata | output | 32 | Request write data |
| sb_rsp_valid | input | 1 | Sideband response valid |
| sb_rsp_rdata | input | 32 | Response read data |
| sb_rsp_err | input | 1 | Response error flag |

## Verification
A launching command write shows up as a valid request one cycle after the write strobe is sampled. A completion shows up in the status and data registers one cycle after the response strobe is sampled, and any register read returns one cycle after its strobe. The bench drives every strobe on the falling edge for exactly one cycle, so each result is due by the next falling edge, and it samples there. Refused commands are checked right after the command write, both on the request line and through a status read. A bench counter of ready-and-valid edges confirms that each command causes exactly one request or none.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int WORD_W  = 32;
  localparam int OP_W    = 8;
  localparam int PORT_W  = 8;
  localparam int BE_W    = 4;
  localparam int LOADR_W = 8;

  localparam int OP_LSB   = 24;
  localparam int PORT_LSB = 16;
  localparam int LOA_LSB  = 8;
  localparam int BE_LSB   = 4;

  localparam int ST_BUSY_BIT = 0;
  localparam int ST_ERR_BIT  = 1;

  typedef enum logic [1:0] {
    REG_CMD   = 2'd0,
    REG_DATA  = 2'd1,
    REG_XADDR = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sbm_cmd_decode.sv
module sbm_cmd_decode
  import sbm_pkg::*;
#(
  parameter int                SB_AW        = 32,
  parameter logic [PORT_W-1:0] BLOCKED_PORT = 8'h06
) (
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [SB_AW-1:0]  xaddr,
  output logic [OP_W-1:0]   op,
  output logic [PORT_W-1:0] port,
  output logic [BE_W-1:0]   be,
  output logic [SB_AW-1:0]  eff_addr,
  output logic              be_none,
  output logic              port_blocked
);
  logic [LOADR_W-1:0] lo_byte;

  always_comb begin
    op           = cmd_word[OP_LSB +: OP_W];
    port         = cmd_word[PORT_LSB +: PORT_W];
    be           = cmd_word[BE_LSB +: BE_W];
    lo_byte      = cmd_word[LOA_LSB +: LOADR_W];
    eff_addr     = xaddr | SB_AW'(lo_byte);
    be_none      = (be == '0);
    port_blocked = (port == BLOCKED_PORT);
  end
endmodule

// File: rtl/sbm_seq.sv
module sbm_seq
  import sbm_pkg::*;
#(
  parameter int                SB_AW        = 32,
  parameter logic [PORT_W-1:0] BLOCKED_PORT = 8'h06
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   in_op,
  input  logic [PORT_W-1:0] in_port,
  input  logic [BE_W-1:0]   in_be,
  input  logic [SB_AW-1:0]  in_addr,
  input  logic [WORD_W-1:0] in_wdata,
  output logic              busy,
  output logic              done,
  output logic              sb_req_valid,
  input  logic              sb_req_ready,
  output logic [OP_W-1:0]   sb_req_op,
  output logic [PORT_W-1:0] sb_req_port,
  output logic [SB_AW-1:0]  sb_req_addr,
  output logic [BE_W-1:0]   sb_req_be,
  output logic [WORD_W-1:0] sb_req_wdata,
  input  logic              sb_rsp_valid
);
  seq_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= SQ_IDLE;
      sb_req_valid <= 1'b0;
      sb_req_op    <= '0;
      sb_req_port  <= '0;
      sb_req_addr  <= '0;
      sb_req_be    <= '0;
      sb_req_wdata <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start) begin
          state_q      <= SQ_REQ;
          sb_req_valid <= 1'b1;
          sb_req_op    <= in_op;
          sb_req_port  <= in_port;
          sb_req_addr  <= in_addr;
          sb_req_be    <= in_be;
          sb_req_wdata <= in_wdata;
        end
        SQ_REQ: if (sb_req_ready) begin
          state_q      <= SQ_WAIT;
          sb_req_valid <= 1'b0;
        end
        SQ_WAIT: if (sb_rsp_valid) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy = (state_q != SQ_IDLE);
  assign done = (state_q == SQ_WAIT) && sb_rsp_valid;

  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> sb_req_valid);
  p_req_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (sb_req_valid && !sb_req_ready) |=> (sb_req_valid && $stable(sb_req_op) &&
      $stable(sb_req_port) && $stable(sb_req_addr) && $stable(sb_req_be) &&
      $stable(sb_req_wdata)));
  p_busy_cover_r8: assert property (@(posedge clk) disable iff (rst)
    sb_req_valid |-> busy);
  p_no_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    sb_req_valid |-> (sb_req_port != BLOCKED_PORT));
  p_be_present_r6: assert property (@(posedge clk) disable iff (rst)
    sb_req_valid |-> (sb_req_be != '0));
endmodule

// File: rtl/sbm_bridge.sv
module sbm_bridge
  import sbm_pkg::*;
#(
  parameter int                SB_AW        = 32,
  parameter int                CFG_AW       = 2,
  parameter logic [PORT_W-1:0] BLOCKED_PORT = 8'h06
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              sb_req_valid,
  input  logic              sb_req_ready,
  output logic [7:0]        sb_req_op,
  output logic [7:0]        sb_req_port,
  output logic [SB_AW-1:0]  sb_req_addr,
  output logic [3:0]        sb_req_be,
  output logic [31:0]       sb_req_wdata,
  input  logic              sb_rsp_valid,
  input  logic [31:0]       sb_rsp_rdata,
  input  logic              sb_rsp_err
);
  logic [WORD_W-1:0] cmd_q, data_q;
  logic [SB_AW-1:0]  xaddr_q;
  logic              err_q;

  logic [OP_W-1:0]   d_op;
  logic [PORT_W-1:0] d_port;
  logic [BE_W-1:0]   d_be;
  logic [SB_AW-1:0]  d_addr;
  logic              d_be_none, d_blocked;
  logic              busy, done;
  logic              sel_cmd, sel_data, sel_xaddr, sel_stat;
  logic              cmd_we, start, refuse;

  always_comb begin
    sel_cmd   = (cfg_addr == CFG_AW'(REG_CMD));
    sel_data  = (cfg_addr == CFG_AW'(REG_DATA));
    sel_xaddr = (cfg_addr == CFG_AW'(REG_XADDR));
    sel_stat  = (cfg_addr == CFG_AW'(REG_STAT));
    cmd_we    = cfg_wr && sel_cmd && !busy;
    start     = cmd_we && !d_be_none && !d_blocked;
    refuse    = cmd_we && !d_be_none && d_blocked;
  end

  sbm_cmd_decode #(.SB_AW(SB_AW), .BLOCKED_PORT(BLOCKED_PORT)) u_dec (
    .cmd_word     (cfg_wdata),
    .xaddr        (xaddr_q),
    .op           (d_op),
    .port         (d_port),
    .be           (d_be),
    .eff_addr     (d_addr),
    .be_none      (d_be_none),
    .port_blocked (d_blocked)
  );

  sbm_seq #(.SB_AW(SB_AW), .BLOCKED_PORT(BLOCKED_PORT)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .in_op        (d_op),
    .in_port      (d_port),
    .in_be        (d_be),
    .in_addr      (d_addr),
    .in_wdata     (data_q),
    .busy         (busy),
    .done         (done),
    .sb_req_valid (sb_req_valid),
    .sb_req_ready (sb_req_ready),
    .sb_req_op    (sb_req_op),
    .sb_req_port  (sb_req_port),
    .sb_req_addr  (sb_req_addr),
    .sb_req_be    (sb_req_be),
    .sb_req_wdata (sb_req_wdata),
    .sb_rsp_valid (sb_rsp_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      data_q  <= '0;
      xaddr_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (cmd_we) cmd_q <= cfg_wdata;
      if (cfg_wr && sel_xaddr && !busy) xaddr_q <= SB_AW'(cfg_wdata);
      if (done && !sb_rsp_err && !sb_req_op[0]) data_q <= sb_rsp_rdata;
      else if (cfg_wr && sel_data && !busy) data_q <= cfg_wdata;
      if (refuse || (done && sb_rsp_err)) err_q <= 1'b1;
      else if (cfg_wr && sel_stat && cfg_wdata[ST_ERR_BIT]) err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else if (cfg_rd) begin
      unique case (1'b1)
        sel_cmd:   cfg_rdata <= cmd_q;
        sel_data:  cfg_rdata <= data_q;
        sel_xaddr: cfg_rdata <= 32'(xaddr_q);
        sel_stat:  cfg_rdata <= 32'({err_q, busy});
        default:   cfg_rdata <= '0;
      endcase
    end
  end

  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(data_q));
  p_xaddr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(xaddr_q));
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(cfg_wr && sel_stat && cfg_wdata[ST_ERR_BIT])) |=> err_q);
  p_refuse_err_r7: assert property (@(posedge clk) disable iff (rst)
    refuse |=> (err_q && !sb_req_valid));
endmodule

// File: tb/tb_sbm_bridge.sv
module tb_sbm_bridge;
  localparam logic [7:0] BLK = 8'h06;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 0, cfg_rd = 0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sb_req_valid, sb_req_ready = 0;
  logic [7:0]  sb_req_op, sb_req_port;
  logic [31:0] sb_req_addr;
  logic [3:0]  sb_req_be;
  logic [31:0] sb_req_wdata;
  logic        sb_rsp_valid = 0, sb_rsp_err = 0;
  logic [31:0] sb_rsp_rdata = '0;

  int checks = 0, errors = 0, hs_count = 0;
  logic [31:0] m_data = 0, m_xaddr = 0;
  logic        m_err = 0;

  always #2.5 clk = ~clk;

  sbm_bridge #(.SB_AW(32), .CFG_AW(2), .BLOCKED_PORT(BLK)) dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sb_req_valid(sb_req_valid),
    .sb_req_ready(sb_req_ready), .sb_req_op(sb_req_op), .sb_req_port(sb_req_port),
    .sb_req_addr(sb_req_addr), .sb_req_be(sb_req_be), .sb_req_wdata(sb_req_wdata),
    .sb_rsp_valid(sb_rsp_valid), .sb_rsp_rdata(sb_rsp_rdata), .sb_rsp_err(sb_rsp_err));

  always @(posedge clk) if (sb_req_valid && sb_req_ready) hs_count <= hs_count + 1;

  function automatic logic [31:0] rd_model(logic [31:0] a, logic [7:0] p);
    return (a * 32'h9E37_79B1) ^ {p, 24'h5A_C3_11};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic cfg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); cfg_rd = 1; cfg_addr = a;
    @(negedge clk); cfg_rd = 0; d = cfg_rdata;
  endtask

  task automatic do_txn(logic [7:0] op, logic [7:0] port, logic [7:0] lo,
                        logic [3:0] be, logic inj_err, logic poke);
    logic [31:0] r, cmdw, rdv;
    int h0;
    logic launch;
    launch = (be != 0) && (port != BLK);
    cmdw = {op, port, lo, be, 4'h0};
    h0 = hs_count;
    cfg_write(2'd0, cmdw);
    chk("R2 R6 R7 request raised", {31'b0, sb_req_valid}, {31'b0, launch});
    if (!launch) begin
      if (be != 0) m_err = 1;
      cfg_read(2'd3, r);
      chk("R6 R7 status after refused/empty command", r, {30'b0, m_err, 1'b0});
      chk("R6 R7 no handshake", hs_count, h0);
      cfg_read(2'd0, r);
      chk("R13 command readback", r, cmdw);
      return;
    end
    cfg_read(2'd3, r);
    chk("R8 busy while open", r[0], 1'b1);
    if (poke) begin
      cfg_write(2'd1, ~m_data);
      cfg_write(2'd2, 32'hFFFF_0000);
      cfg_write(2'd0, 32'h0107_00F0);
      cfg_read(2'd1, r);
      chk("R9 data read while busy", r, m_data);
    end
    repeat ($urandom_range(0, 3)) @(negedge clk);
    chk("R2 op", sb_req_op, op);
    chk("R2 port", sb_req_port, port);
    chk("R2 be", sb_req_be, be);
    chk("R3 address", sb_req_addr, m_xaddr | {24'b0, lo});
    if (op[0]) chk("R4 write data", sb_req_wdata, m_data);
    chk("R10 still valid", {31'b0, sb_req_valid}, 32'd1);
    @(negedge clk); sb_req_ready = 1;
    @(negedge clk); sb_req_ready = 0;
    repeat ($urandom_range(0, 3)) @(negedge clk);
    rdv = rd_model(m_xaddr | {24'b0, lo}, port);
    sb_rsp_valid = 1; sb_rsp_rdata = rdv; sb_rsp_err = inj_err;
    @(negedge clk); sb_rsp_valid = 0; sb_rsp_err = 0;
    if (inj_err) m_err = 1;
    else if (!op[0]) m_data = rdv;
    cfg_read(2'd3, r);
    chk("R8 R11 status after completion", r, {30'b0, m_err, 1'b0});
    cfg_read(2'd1, r);
    chk("R4 R5 R11 data after completion", r, m_data);
    chk("R2 one handshake", hs_count, h0 + 1);
    if (poke) begin
      cfg_read(2'd2, r);
      chk("R9 xaddr write ignored", r, m_xaddr);
      cfg_read(2'd0, r);
      chk("R9 R13 command write ignored", r, cmdw);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 request idle", {31'b0, sb_req_valid}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      cfg_read(i[1:0], r);
      chk("R1 R13 reset register", r, 32'd0);
    end
    // directed: write transaction with upper address
    m_data = 32'hCAFE_F00D; cfg_write(2'd1, m_data);
    m_xaddr = 32'h0001_2300; cfg_write(2'd2, m_xaddr);
    do_txn(8'h11, 8'h03, 8'h45, 4'hF, 0, 1);
    // directed: read
    do_txn(8'h10, 8'h04, 8'hFF, 4'h3, 0, 0);
    // directed: byte enables zero
    do_txn(8'h10, 8'h04, 8'h01, 4'h0, 0, 0);
    // directed: blocked port with and without enables
    do_txn(8'h10, BLK, 8'h01, 4'h0, 0, 0);
    do_txn(8'h11, BLK, 8'h02, 4'h1, 0, 0);
    // R12: write 0 keeps error, write bit1 clears
    cfg_write(2'd3, 32'h1);
    cfg_read(2'd3, r); chk("R12 error kept by write 0", r, 32'h2);
    cfg_write(2'd3, 32'h2); m_err = 0;
    cfg_read(2'd3, r); chk("R12 error cleared", r, 32'h0);
    // directed: errored read keeps data
    do_txn(8'h00, 8'h05, 8'h10, 4'h8, 1, 1);
    cfg_write(2'd3, 32'h2); m_err = 0;
    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [7:0] op, port;
      logic [3:0] be;
      if ($urandom_range(0, 3) == 0) begin
        m_xaddr = $urandom() & 32'hFFFF_FF00; cfg_write(2'd2, m_xaddr);
      end
      if ($urandom_range(0, 2) == 0) begin
        m_data = $urandom(); cfg_write(2'd1, m_data);
      end
      op = 8'($urandom());
      port = ($urandom_range(0, 7) == 0) ? BLK : 8'($urandom());
      be = ($urandom_range(0, 7) == 0) ? 4'h0 : 4'($urandom());
      do_txn(op, port, 8'($urandom()), be, ($urandom_range(0, 7) == 0),
             ($urandom_range(0, 3) == 0));
      if (m_err && $urandom_range(0, 1) == 1) begin
        cfg_write(2'd3, 32'h2); m_err = 0;
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule